// File: doc/BRIEF.md
# Dependence-Steered Issue Queue Unit

This unit sits after register renaming and places each renamed instruction into one of a set of in-order issue FIFOs. Dependent instructions are kept together: when an instruction's outstanding source is produced by the instruction at the tail of some FIFO, the new instruction is appended directly behind it. Otherwise it takes an empty FIFO from the pool. The result is that only the instruction at the head of each FIFO ever needs a readiness check. No tag has to be broadcast across a large window.

Readiness is a lookup in a bit vector with one bit per physical register. The bit is set when a writer of that register is steered and cleared when the result is reported complete. A per-logical-register table records which FIFO holds the pending writer of each register and which physical register that writer targets. Each cycle, up to a configurable number of ready heads are issued, lowest-numbered FIFO first. A FIFO that drains returns to the pool. One instruction is steered per cycle. When no FIFO fits and no empty FIFO exists, the unit raises a stall and accepts nothing.

Top module: `dep_steer_unit`

## Requirements
- R1: After reset, every FIFO is empty and free, no reservation bit is set, no table entry is valid and no issue slot is valid. The first instruction accepted goes to FIFO 0.
- R2: A source is outstanding when its logical register has a valid table entry. An instruction with no outstanding source goes to the lowest-numbered empty FIFO. `steer_q` carries the binary FIFO index.
- R3: An instruction with one outstanding source is appended to the producer's FIFO when that FIFO is non-empty and not full, and its tail instruction writes the physical register named in the table entry.
- R4: When the producer is not the tail of its FIFO, or that FIFO holds its full depth, the instruction goes to the lowest-numbered empty FIFO instead.
- R5: With two outstanding sources, the left (a) source's FIFO is tried first. The right (b) source's FIFO is tried only when the left one does not fit.
- R6: When no FIFO fits and no FIFO is empty, `steer_stall` is high while `in_valid` is high, and the instruction is not accepted. `steer_stall` is low whenever `in_valid` is low.
- R7: A FIFO whose last instruction issues is empty from the next cycle on and can be chosen for a new instruction.
- R8: An accepted instruction with a destination sets that physical register's reservation bit. A completion on `cmp_preg` clears it. A head issues only when the reservation bits of all its valid sources are clear.
- R9: Only FIFO heads issue, each FIFO in order. Up to ISSUE_W heads issue per cycle, packed into slots from slot 0, with the lowest-numbered FIFO in slot 0. Slot w uses bits [w*3 +: 3] of `iss_q` and [w*8 +: 8] of `iss_tag` at default widths.
- R10: A completion invalidates a logical register's table entry only if that entry still records the completing physical register.
- R11: Steering an instruction with a destination makes the table entry of its logical destination name the chosen FIFO and its physical destination.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A renamed instruction is offered |
| in_tag | input | TAG_W | Identifier carried to issue |
| in_src_a_vld | input | 1 | Left source is used |
| in_src_a_lreg | input | LW | Left source logical register |
| in_src_a_preg | input | PW | Left source physical register |
| in_src_b_vld | input | 1 | Right source is used |
| in_src_b_lreg | input | LW | Right source logical register |
| in_src_b_preg | input | PW | Right source physical register |
| in_dst_vld | input | 1 | Instruction writes a register |
| in_dst_lreg | input | LW | Destination logical register |
| in_dst_preg | input | PW | Destination physical register |
| steer_stall | output | 1 | Offered instruction cannot be placed this cycle |
| steer_q | output | QW | FIFO chosen for the offered instruction |
| cmp_vld | input | 1 | A result is produced this cycle |
| cmp_preg | input | PW | Physical register of that result |
| iss_vld | output | ISSUE_W | Issue slot valid bits |
| iss_q | output | ISSUE_W*QW | Source FIFO per issue slot |
| iss_tag | output | ISSUE_W*TAG_W | Instruction tag per issue slot |

## Verification
Several patterns drive the steering decision. A run of dependent instructions whose producer is still at a tail must stay in one FIFO. A consumer whose producer has already been covered by a later instruction must move to a fresh FIFO. A two-source instruction whose left producer is buried must fall back to the right source, and when both sources fit the left must win. One chain is grown to the full FIFO depth to separate the full fallback from the tail test. All FIFOs are then occupied to provoke a stall, and the stall must lift exactly one cycle after a FIFO drains. Completions are timed to release two heads in one cycle, which checks slot ordering. A register is also redefined before its old producer completes, which shows whether invalidation compares the producer tag.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
   typedef enum logic [1:0] {
      PICK_LEFT  = 2'd0,
      PICK_RIGHT = 2'd1,
      PICK_NEW   = 2'd2,
      PICK_NONE  = 2'd3
   } steer_pick_e;
endpackage

// File: rtl/dsu_fifo.sv
module dsu_fifo #(
   parameter int DEPTH = 8,
   parameter int EW    = 16,
   parameter int PW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [EW-1:0] wdata,
   input  logic          wdst_vld,
   input  logic [PW-1:0] wdst_preg,
   output logic [EW-1:0] head,
   output logic          empty,
   output logic          full,
   output logic          tail_dst_vld,
   output logic [PW-1:0] tail_preg
);
   localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);

   logic [EW-1:0]   mem [DEPTH];
   logic [PTRW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0]   cnt;
   logic            do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign head    = mem[rd_ptr];

   function automatic logic [PTRW-1:0] nxt(input logic [PTRW-1:0] p);
      return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr       <= '0;
         wr_ptr       <= '0;
         cnt          <= '0;
         tail_dst_vld <= 1'b0;
         tail_preg    <= '0;
      end else begin
         if (do_push) begin
            wr_ptr       <= nxt(wr_ptr);
            tail_dst_vld <= wdst_vld;
            tail_preg    <= wdst_preg;
         end
         if (do_pop) rd_ptr <= nxt(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/dsu_prod_table.sv
module dsu_prod_table #(
   parameter int NUM_LREG = 32,
   parameter int QW       = 3,
   parameter int PW       = 6,
   localparam int LW      = $clog2(NUM_LREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rd_a_lreg,
   output logic          rd_a_vld,
   output logic [QW-1:0] rd_a_q,
   output logic [PW-1:0] rd_a_preg,
   input  logic [LW-1:0] rd_b_lreg,
   output logic          rd_b_vld,
   output logic [QW-1:0] rd_b_q,
   output logic [PW-1:0] rd_b_preg,
   input  logic          wr_en,
   input  logic [LW-1:0] wr_lreg,
   input  logic [QW-1:0] wr_q,
   input  logic [PW-1:0] wr_preg,
   input  logic          cmp_vld,
   input  logic [PW-1:0] cmp_preg
);
   logic          ent_vld  [NUM_LREG];
   logic [QW-1:0] ent_q    [NUM_LREG];
   logic [PW-1:0] ent_preg [NUM_LREG];

   for (genvar i = 0; i < NUM_LREG; i++) begin : g_ent
      logic hit_wr, hit_cmp;
      assign hit_wr  = wr_en & (wr_lreg == LW'(i));
      assign hit_cmp = cmp_vld & ent_vld[i] & (ent_preg[i] == cmp_preg);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_vld[i]  <= 1'b0;
            ent_q[i]    <= '0;
            ent_preg[i] <= '0;
         end else if (hit_wr) begin
            ent_vld[i]  <= 1'b1;
            ent_q[i]    <= wr_q;
            ent_preg[i] <= wr_preg;
         end else if (hit_cmp) begin
            ent_vld[i]  <= 1'b0;
         end
      end
   end

   assign rd_a_vld  = ent_vld[rd_a_lreg];
   assign rd_a_q    = ent_q[rd_a_lreg];
   assign rd_a_preg = ent_preg[rd_a_lreg];
   assign rd_b_vld  = ent_vld[rd_b_lreg];
   assign rd_b_q    = ent_q[rd_b_lreg];
   assign rd_b_preg = ent_preg[rd_b_lreg];
endmodule

// File: rtl/dsu_resv.sv
module dsu_resv #(
   parameter int NUM_PREG = 64,
   localparam int PW      = $clog2(NUM_PREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [PW-1:0]       set_preg,
   input  logic                clr_en,
   input  logic [PW-1:0]       clr_preg,
   output logic [NUM_PREG-1:0] resv
);
   for (genvar i = 0; i < NUM_PREG; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                                resv[i] <= 1'b0;
         else if (set_en && set_preg == PW'(i))     resv[i] <= 1'b1;
         else if (clr_en && clr_preg == PW'(i))     resv[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/dsu_issue_sel.sv
module dsu_issue_sel #(
   parameter int NQ = 8,
   parameter int IW = 2,
   localparam int QW = $clog2(NQ)
) (
   input  logic [NQ-1:0]    rdy,
   output logic [NQ-1:0]    grant,
   output logic [IW-1:0]    slot_vld,
   output logic [IW*QW-1:0] slot_q
);
   if (IW == 1) begin : g_single
      always_comb begin
         grant    = '0;
         slot_vld = '0;
         slot_q   = '0;
         for (int q = NQ - 1; q >= 0; q--) begin
            if (rdy[q]) begin
               grant       = '0;
               grant[q]    = 1'b1;
               slot_vld[0] = 1'b1;
               slot_q      = QW'(q);
            end
         end
      end
   end else begin : g_multi
      always_comb begin
         int n;
         n        = 0;
         grant    = '0;
         slot_vld = '0;
         slot_q   = '0;
         for (int q = 0; q < NQ; q++) begin
            if (rdy[q] && n < IW) begin
               grant[q]              = 1'b1;
               slot_vld[n]           = 1'b1;
               slot_q[n*QW +: QW]    = QW'(q);
               n                     = n + 1;
            end
         end
      end
   end
endmodule

// File: rtl/dep_steer_unit.sv
module dep_steer_unit #(
   parameter int NUM_Q    = 8,
   parameter int Q_DEPTH  = 8,
   parameter int NUM_LREG = 32,
   parameter int NUM_PREG = 64,
   parameter int TAG_W    = 8,
   parameter int ISSUE_W  = 2,
   localparam int QW      = $clog2(NUM_Q),
   localparam int LW      = $clog2(NUM_LREG),
   localparam int PW      = $clog2(NUM_PREG)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [TAG_W-1:0]      in_tag,
   input  logic                  in_src_a_vld,
   input  logic [LW-1:0]         in_src_a_lreg,
   input  logic [PW-1:0]         in_src_a_preg,
   input  logic                  in_src_b_vld,
   input  logic [LW-1:0]         in_src_b_lreg,
   input  logic [PW-1:0]         in_src_b_preg,
   input  logic                  in_dst_vld,
   input  logic [LW-1:0]         in_dst_lreg,
   input  logic [PW-1:0]         in_dst_preg,
   output logic                  steer_stall,
   output logic [QW-1:0]         steer_q,
   input  logic                  cmp_vld,
   input  logic [PW-1:0]         cmp_preg,
   output logic [ISSUE_W-1:0]    iss_vld,
   output logic [ISSUE_W*QW-1:0] iss_q,
   output logic [ISSUE_W*TAG_W-1:0] iss_tag
);
   import dsu_pkg::*;

   localparam int EW     = TAG_W + 2 + 2 * PW;
   localparam int OFS_BP = 0;
   localparam int OFS_BV = PW;
   localparam int OFS_AP = PW + 1;
   localparam int OFS_AV = 2 * PW + 1;
   localparam int OFS_TG = 2 * PW + 2;

   if (NUM_Q < 2) begin : g_bad_nq
      $error("dep_steer_unit: NUM_Q must be at least 2");
   end
   if (Q_DEPTH < 2) begin : g_bad_depth
      $error("dep_steer_unit: Q_DEPTH must be at least 2");
   end
   if (ISSUE_W < 1 || ISSUE_W > NUM_Q) begin : g_bad_iw
      $error("dep_steer_unit: ISSUE_W must lie in 1..NUM_Q");
   end
   if ((1 << QW) != NUM_Q) begin : g_bad_pow
      $error("dep_steer_unit: NUM_Q must be a power of two");
   end

   // table lookup
   logic          ta_vld, tb_vld;
   logic [QW-1:0] ta_q, tb_q;
   logic [PW-1:0] ta_preg, tb_preg;
   logic          accept;
   steer_pick_e   pick;
   logic [QW-1:0] tgt_q;

   dsu_prod_table #(.NUM_LREG(NUM_LREG), .QW(QW), .PW(PW)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_a_lreg (in_src_a_lreg),
      .rd_a_vld  (ta_vld),
      .rd_a_q    (ta_q),
      .rd_a_preg (ta_preg),
      .rd_b_lreg (in_src_b_lreg),
      .rd_b_vld  (tb_vld),
      .rd_b_q    (tb_q),
      .rd_b_preg (tb_preg),
      .wr_en     (accept & in_dst_vld),
      .wr_lreg   (in_dst_lreg),
      .wr_q      (tgt_q),
      .wr_preg   (in_dst_preg),
      .cmp_vld   (cmp_vld),
      .cmp_preg  (cmp_preg)
   );

   // reservation bits
   logic [NUM_PREG-1:0] resv_q;

   dsu_resv #(.NUM_PREG(NUM_PREG)) u_resv (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (accept & in_dst_vld),
      .set_preg (in_dst_preg),
      .clr_en   (cmp_vld),
      .clr_preg (cmp_preg),
      .resv     (resv_q)
   );

   // FIFO bank
   logic [NUM_Q-1:0] q_empty, q_full, q_tdv, q_push, q_pop, q_rdy;
   logic [PW-1:0]    q_tpreg [NUM_Q];
   logic [EW-1:0]    q_head  [NUM_Q];
   logic [EW-1:0]    wentry;

   assign wentry = {in_tag, in_src_a_vld, in_src_a_preg, in_src_b_vld, in_src_b_preg};

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic          h_av, h_bv;
      logic [PW-1:0] h_ap, h_bp;

      assign q_push[q] = accept & (tgt_q == QW'(q));

      dsu_fifo #(.DEPTH(Q_DEPTH), .EW(EW), .PW(PW)) u_fifo (
         .clk          (clk),
         .rst_n        (rst_n),
         .push         (q_push[q]),
         .pop          (q_pop[q]),
         .wdata        (wentry),
         .wdst_vld     (in_dst_vld),
         .wdst_preg    (in_dst_preg),
         .head         (q_head[q]),
         .empty        (q_empty[q]),
         .full         (q_full[q]),
         .tail_dst_vld (q_tdv[q]),
         .tail_preg    (q_tpreg[q])
      );

      assign h_av = q_head[q][OFS_AV];
      assign h_ap = q_head[q][OFS_AP +: PW];
      assign h_bv = q_head[q][OFS_BV];
      assign h_bp = q_head[q][OFS_BP +: PW];
      assign q_rdy[q] = ~q_empty[q] & (~h_av | ~resv_q[h_ap]) & (~h_bv | ~resv_q[h_bp]);
   end

   // steering decision
   logic          a_fit, b_fit, free_found;
   logic [QW-1:0] free_q;

   always_comb begin
      free_found = 1'b0;
      free_q     = '0;
      for (int q = NUM_Q - 1; q >= 0; q--) begin
         if (q_empty[q]) begin
            free_found = 1'b1;
            free_q     = QW'(q);
         end
      end
   end

   assign a_fit = in_src_a_vld & ta_vld & ~q_empty[ta_q] & q_tdv[ta_q] &
                  (q_tpreg[ta_q] == ta_preg) & ~q_full[ta_q];
   assign b_fit = in_src_b_vld & tb_vld & ~q_empty[tb_q] & q_tdv[tb_q] &
                  (q_tpreg[tb_q] == tb_preg) & ~q_full[tb_q];

   always_comb begin
      if (a_fit)           pick = PICK_LEFT;
      else if (b_fit)      pick = PICK_RIGHT;
      else if (free_found) pick = PICK_NEW;
      else                 pick = PICK_NONE;
      case (pick)
         PICK_LEFT:  tgt_q = ta_q;
         PICK_RIGHT: tgt_q = tb_q;
         default:    tgt_q = free_q;
      endcase
   end

   assign steer_stall = in_valid & (pick == PICK_NONE);
   assign accept      = in_valid & (pick != PICK_NONE);
   assign steer_q     = tgt_q;

   // issue from heads
   dsu_issue_sel #(.NQ(NUM_Q), .IW(ISSUE_W)) u_sel (
      .rdy      (q_rdy),
      .grant    (q_pop),
      .slot_vld (iss_vld),
      .slot_q   (iss_q)
   );

   always_comb begin
      for (int w = 0; w < ISSUE_W; w++) begin
         iss_tag[w*TAG_W +: TAG_W] = q_head[iss_q[w*QW +: QW]][OFS_TG +: TAG_W];
      end
   end
endmodule

// File: rtl/dsu_checker.sv
module dsu_checker #(
   parameter int NUM_Q    = 8,
   parameter int NUM_PREG = 64,
   parameter int ISSUE_W  = 2,
   localparam int QW      = $clog2(NUM_Q),
   localparam int PW      = $clog2(NUM_PREG)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  in_dst_vld,
   input logic [PW-1:0]         in_dst_preg,
   input logic                  steer_stall,
   input logic [QW-1:0]         steer_q,
   input logic                  cmp_vld,
   input logic [PW-1:0]         cmp_preg,
   input logic [ISSUE_W-1:0]    iss_vld,
   input logic [ISSUE_W*QW-1:0] iss_q,
   input logic [NUM_Q-1:0]      q_empty,
   input logic [NUM_Q-1:0]      q_full,
   input logic [NUM_PREG-1:0]   resv_q
);
   AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> !steer_stall); // R6

   AST_STALL_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      steer_stall |-> (q_empty == '0)); // R6

   AST_ACCEPT_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !steer_stall) |-> !q_full[steer_q]); // R4

   AST_RESV_ON_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !steer_stall && in_dst_vld && !(cmp_vld && cmp_preg == in_dst_preg))
      |=> resv_q[$past(in_dst_preg)]); // R8

   AST_ISSUE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[0] |-> !q_empty[iss_q[QW-1:0]]); // R9

   for (genvar w = 1; w < ISSUE_W; w++) begin : g_ord
      AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
         iss_vld[w] |-> (iss_vld[w-1] && (iss_q[(w-1)*QW +: QW] < iss_q[w*QW +: QW]))); // R9
   end
endmodule

bind dep_steer_unit dsu_checker #(
   .NUM_Q    (NUM_Q),
   .NUM_PREG (NUM_PREG),
   .ISSUE_W  (ISSUE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_dst_vld  (in_dst_vld),
   .in_dst_preg (in_dst_preg),
   .steer_stall (steer_stall),
   .steer_q     (steer_q),
   .cmp_vld     (cmp_vld),
   .cmp_preg    (cmp_preg),
   .iss_vld     (iss_vld),
   .iss_q       (iss_q),
   .q_empty     (q_empty),
   .q_full      (q_full),
   .resv_q      (resv_q)
);

// File: tb/sim_dep_steer_unit.sv
module sim_dep_steer_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [7:0]  in_tag;
   logic        in_src_a_vld, in_src_b_vld, in_dst_vld;
   logic [4:0]  in_src_a_lreg, in_src_b_lreg, in_dst_lreg;
   logic [5:0]  in_src_a_preg, in_src_b_preg, in_dst_preg;
   logic        steer_stall;
   logic [2:0]  steer_q;
   logic        cmp_vld;
   logic [5:0]  cmp_preg;
   logic [1:0]  iss_vld;
   logic [5:0]  iss_q;
   logic [15:0] iss_tag;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   dep_steer_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
      .in_src_a_vld(in_src_a_vld), .in_src_a_lreg(in_src_a_lreg), .in_src_a_preg(in_src_a_preg),
      .in_src_b_vld(in_src_b_vld), .in_src_b_lreg(in_src_b_lreg), .in_src_b_preg(in_src_b_preg),
      .in_dst_vld(in_dst_vld), .in_dst_lreg(in_dst_lreg), .in_dst_preg(in_dst_preg),
      .steer_stall(steer_stall), .steer_q(steer_q), .cmp_vld(cmp_vld), .cmp_preg(cmp_preg),
      .iss_vld(iss_vld), .iss_q(iss_q), .iss_tag(iss_tag)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FIFO-steer FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_q(input string req, input int exp);
      chk(!steer_stall && steer_q == 3'(exp), req, int'(steer_q), exp);
   endtask

   // drive one cycle at the falling edge, outputs settle 1 ns later
   task automatic step(input logic v, input logic av, input int al, input int ap,
                       input logic bv, input int bl, input int bp,
                       input logic dv, input int dl, input int dp, input int tg,
                       input logic cv, input int cp);
      @(negedge clk);
      in_valid = v; in_tag = 8'(tg);
      in_src_a_vld = av; in_src_a_lreg = 5'(al); in_src_a_preg = 6'(ap);
      in_src_b_vld = bv; in_src_b_lreg = 5'(bl); in_src_b_preg = 6'(bp);
      in_dst_vld = dv; in_dst_lreg = 5'(dl); in_dst_preg = 6'(dp);
      cmp_vld = cv; cmp_preg = 6'(cp);
      #1;
   endtask

   task automatic idle(input logic cv, input int cp);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, cv, cp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 0; cmp_vld = 0; in_src_a_vld = 0; in_src_b_vld = 0; in_dst_vld = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_chains();
      do_reset();
      #1;
      chk(iss_vld == 2'b00 && !steer_stall, "R1 reset idle", int'(iss_vld), 0);
      // c0: A no sources, writes lr1/p1
      step(1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
      chk_q("R1 first to fifo0", 0);
      // c1: A issues; B reads lr1 -> behind A
      step(1, 1, 1, 1, 0, 0, 0, 1, 2, 2, 2, 0, 0);
      chk(iss_vld == 2'b01 && iss_q[2:0] == 3'd0 && iss_tag[7:0] == 8'd1, "R9 A issues", int'(iss_tag[7:0]), 1);
      chk_q("R3 append behind tail", 0);
      // c2: B waits on p1; C reads lr2
      step(1, 1, 2, 2, 0, 0, 0, 1, 3, 3, 3, 0, 0);
      chk(iss_vld == 2'b00, "R8 head blocked by reservation", int'(iss_vld), 0);
      chk_q("R3 chain grows", 0);
      // c3: D reads lr1, producer no longer tail
      step(1, 1, 1, 1, 0, 0, 0, 1, 4, 4, 4, 0, 0);
      chk_q("R4 producer buried", 1);
      // c4: E left lr1 buried, right lr3 tail of fifo0
      step(1, 1, 1, 1, 1, 3, 3, 1, 5, 5, 5, 0, 0);
      chk_q("R5 right fallback", 0);
      // c5: F left lr4 tail of fifo1, right lr5 tail of fifo0
      step(1, 1, 4, 4, 1, 5, 5, 1, 6, 6, 6, 0, 0);
      chk_q("R5 left preferred", 1);
      // c6: G source never written
      step(1, 1, 7, 7, 0, 0, 0, 0, 0, 0, 7, 0, 0);
      chk_q("R2 independent new fifo", 2);
      // c7: G issues
      idle(0, 0);
      chk(iss_vld == 2'b01 && iss_q[2:0] == 3'd2, "R9 independent issues", int'(iss_q[2:0]), 2);
      // c8: complete p1
      idle(1, 1);
      // c9: B and D both ready; H reads lr1 (now invalid)
      step(1, 1, 1, 1, 0, 0, 0, 1, 8, 8, 8, 0, 0);
      chk(iss_vld == 2'b11 && iss_q[2:0] == 3'd0 && iss_q[5:3] == 3'd1, "R9 two heads lowest first",
          int'(iss_q), 8);
      chk(iss_tag[7:0] == 8'd2 && iss_tag[15:8] == 8'd4, "R8 released heads", int'(iss_tag), 16'h0402);
      chk_q("R10 invalidated source is independent", 2);
      // c10: H issues; J redefines lr2 with p20, blocked on p4
      step(1, 1, 9, 4, 0, 0, 0, 1, 2, 20, 9, 0, 0);
      chk(iss_vld == 2'b01 && iss_q[2:0] == 3'd2, "R9 H issues", int'(iss_q[2:0]), 2);
      chk_q("R7 fifo2 not free yet", 3);
      // c11: old producer of lr2 completes
      idle(1, 2);
      // c12: K reads lr2 -> must follow J
      step(1, 1, 2, 20, 0, 0, 0, 0, 0, 0, 10, 0, 0);
      chk_q("R10 stale completion keeps entry R11", 3);
      chk(iss_vld[0] && iss_q[2:0] == 3'd0 && iss_tag[7:0] == 8'd3, "R8 C released", int'(iss_tag[7:0]), 3);
      idle(0, 0);
   endtask

   task automatic t_full_stall();
      do_reset();
      step(1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
      idle(0, 0);
      chk(iss_vld == 2'b01 && iss_q[2:0] == 3'd0, "R9 X issues", int'(iss_vld), 1);
      for (int i = 1; i <= 8; i++) begin
         step(1, 1, (i == 1) ? 0 : i, (i == 1) ? 1 : 9 + i, 0, 0, 0, 1, i + 1, 10 + i, 20 + i, 0, 0);
         chk_q((i == 1) ? "R7 drained fifo reused" : "R3 chain to depth", 0);
      end
      step(1, 1, 9, 18, 0, 0, 0, 0, 0, 0, 30, 0, 0);
      chk_q("R4 full fifo fallback", 1);
      for (int i = 0; i < 6; i++) begin
         step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 40 + i, 0, 0);
         chk_q("R2 fill pool", 2 + i);
      end
      step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 50, 1, 1);
      chk(steer_stall == 1'b1, "R6 stall when pool empty", int'(steer_stall), 1);
      step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 50, 0, 0);
      chk(steer_stall == 1'b1, "R6 stall holds", int'(steer_stall), 1);
      chk(iss_vld == 2'b11 && iss_q[2:0] == 3'd0 && iss_q[5:3] == 3'd2, "R9 width limit",
          int'(iss_q), 16);
      step(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 50, 0, 0);
      chk_q("R7 drained fifo returns", 2);
      chk(iss_vld == 2'b11 && iss_q[2:0] == 3'd3 && iss_q[5:3] == 3'd4, "R9 next heads",
          int'(iss_q), 35);
      idle(0, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      in_valid = 0; in_tag = 0; cmp_vld = 0; cmp_preg = 0;
      in_src_a_vld = 0; in_src_a_lreg = 0; in_src_a_preg = 0;
      in_src_b_vld = 0; in_src_b_lreg = 0; in_src_b_preg = 0;
      in_dst_vld = 0; in_dst_lreg = 0; in_dst_preg = 0;
      t_chains();
      t_full_stall();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FIFO-steer FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule